// File: doc/BRIEF.md
# Sixteen-bit ALU with Stored Zero Flag

This block is the arithmetic logic unit of a small datapath. It takes two 16-bit operands and a 3-bit operation select, and it produces a 16-bit result without any clock delay. The result covers bitwise operations, wrapping addition and subtraction, logical shifts, and a pass-through of the second operand.

Alongside the result, one flip-flop records whether the result was zero. Only addition and subtraction write this flag, on the rising clock edge. Every other operation leaves the flag as it was, so a later conditional step can still test the outcome of the last arithmetic operation. The flag has an asynchronous active-low clear.

Top module: `alu16_zf`

## Requirements
- R1: With op 0 the result is `src_a & src_b`. With op 1 it is `src_a | src_b`. With op 4 it is `src_a ^ src_b`.
- R2: With op 2 the result is `src_a + src_b` modulo 2^16. There is no carry output.
- R3: With op 3 the result is `src_a - src_b` modulo 2^16.
- R4: With op 5 the result is `src_a` shifted right logically by `src_b` places, filling with zeros. A shift amount of 16 or more gives 0.
- R5: With op 6 the result is `src_a` shifted left logically by `src_b` places. A shift amount of 16 or more gives 0.
- R6: With op 7 the result equals `src_b`.
- R7: On a rising clock edge with op 2 or op 3 and `rst_n` high, `zero_flag` takes the value 1 if the result was zero, and 0 otherwise.
- R8: On a rising clock edge with any op other than 2 or 3, `zero_flag` keeps its previous value, even when the result is zero.
- R9: While `rst_n` is low, `zero_flag` is 0. The clear takes effect at once, without waiting for a clock edge.
- R10: `dst` follows `src_a`, `src_b` and `op` combinationally, within the same clock cycle and with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the zero flag |
| rst_n | input | 1 | Asynchronous active-low clear of the zero flag |
| src_a | input | 16 | First operand, and the value shifted by ops 5 and 6 |
| src_b | input | 16 | Second operand, the shift amount, or the value passed through by op 7 |
| op | input | 3 | Operation select, from 0 to 7 |
| dst | output | 16 | Combinational result |
| zero_flag | output | 1 | Stored flag, set when the last addition or subtraction gave zero |

## Verification
The bench tries each operation with operand pairs that make every bit of the result informative. It uses overlapping bit patterns for the logic operations, and sums and differences that wrap through zero. The shift tests separate a shift of 15 from shifts of 16 and above.

The flag is driven to both values by arithmetic. It is then followed by non-updating operations whose result is zero or non-zero. A design that writes the flag on every operation therefore disagrees with the expected flag in either direction.

A clear applied in the middle of a cycle, with the flag set, shows whether the clear is asynchronous. The result is checked before each clock edge, which shows that it does not wait for the clock.

// File: rtl/alu16_pkg.sv
// Package: shared width and operation encoding for the 16-bit ALU.
// Assumes the operation select is 3 bits wide and uses all eight codes.
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHR  = 3'd5,
        OP_SHL  = 3'd6,
        OP_LOAD = 3'd7
    } alu_op_e;

    // Only the arithmetic operations write the stored zero flag.
    function automatic logic op_writes_flag(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu16_bitwise.sv
// Module: bitwise unit for AND, OR and XOR, plus the operand pass-through.
// Assumes the caller chooses this unit's output only for those four ops.
module alu16_bitwise #(
    parameter int DATA_W = alu16_pkg::DATA_W
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  alu16_pkg::alu_op_e       op,
    output logic [DATA_W-1:0]        y
);
    import alu16_pkg::*;

    // Pick the bitwise function that op asks for.
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/alu16_addsub.sv
// Module: shared adder for addition and subtraction, wrapping at DATA_W bits.
// Assumes no carry or overflow is needed. The carry out is dropped.
module alu16_addsub #(
    parameter int DATA_W = alu16_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] b_eff;

    // Invert b and add one for subtraction (two's complement).
    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
    end

endmodule

// File: rtl/alu16_shifter.sv
// Module: logical shifter, one direction chosen by the LEFT parameter.
// Assumes DATA_W is a power of two. Any amount of DATA_W or more gives zero.
module alu16_shifter #(
    parameter int DATA_W = alu16_pkg::DATA_W,
    parameter bit LEFT   = 1'b0
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] amt,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic              too_far;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] shifted;

    // Split the amount into an in-range part and an out-of-range detect.
    always_comb begin
        too_far = |amt[DATA_W-1:SH_W];
        sh      = amt[SH_W-1:0];
    end

    generate
        if (LEFT) begin : g_left
            // Shift left, filling with zeros from the bottom.
            always_comb shifted = a << sh;
        end else begin : g_right
            // Shift right, filling with zeros from the top.
            always_comb shifted = a >> sh;
        end
    endgenerate

    // Force the result to zero when the amount is out of range.
    always_comb y = too_far ? '0 : shifted;

endmodule

// File: rtl/alu16_zf.sv
// Module: 16-bit ALU with a combinational result and a stored zero flag.
// Assumes rst_n is an asynchronous active-low clear that acts on the flag only.
module alu16_zf #(
    parameter int DATA_W = alu16_pkg::DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          src_a,
    input  logic [DATA_W-1:0]          src_b,
    input  logic [alu16_pkg::OP_W-1:0] op,
    output logic [DATA_W-1:0]          dst,
    output logic                       zero_flag
);
    import alu16_pkg::*;

    alu_op_e           op_e;
    logic [DATA_W-1:0] bit_y, arith_y, shr_y, shl_y;
    logic              flag_we;

    // Read the raw select as the enumerated operation type.
    always_comb op_e = alu_op_e'(op);

    alu16_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a(src_a), .b(src_b), .op(op_e), .y(bit_y)
    );

    alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(src_a), .b(src_b), .sub(op_e == OP_SUB), .y(arith_y)
    );

    alu16_shifter #(.DATA_W(DATA_W), .LEFT(1'b0)) u_shr (
        .a(src_a), .amt(src_b), .y(shr_y)
    );

    alu16_shifter #(.DATA_W(DATA_W), .LEFT(1'b1)) u_shl (
        .a(src_a), .amt(src_b), .y(shl_y)
    );

    // Route the output of the unit that op selects to dst.
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: dst = arith_y;
            OP_SHR:         dst = shr_y;
            OP_SHL:         dst = shl_y;
            default:        dst = bit_y;
        endcase
    end

    // Decide whether this cycle writes the zero flag.
    always_comb flag_we = op_writes_flag(op_e);

    // Store the zero detect on arithmetic ops, and clear it at once on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            zero_flag <= 1'b0;
        else if (flag_we)
            zero_flag <= (dst == '0);
    end

endmodule

// File: rtl/alu16_zf_chk.sv
// Module: checker for the ALU's result and flag rules, bound to alu16_zf.
// Assumes it sees only the top module's ports.
module alu16_zf_chk #(
    parameter int DATA_W = alu16_pkg::DATA_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [DATA_W-1:0]          src_b,
    input logic [alu16_pkg::OP_W-1:0] op,
    input logic [DATA_W-1:0]          dst,
    input logic                       zero_flag
);
    // R7: after an add or subtract, the flag reports whether the result was zero.
    p_flag_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 || op == 3'd3) |=> (zero_flag == ($past(dst) == '0)));

    // R8: any other operation leaves the flag unchanged.
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == 3'd2 || op == 3'd3) |=> $stable(zero_flag));

    // R6: the load operation passes the second operand through.
    p_load_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd7) |-> (dst == src_b));

    // R4: a right shift by DATA_W or more gives zero.
    p_shr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && src_b >= DATA_W) |-> (dst == '0));

    // R5: a left shift by DATA_W or more gives zero.
    p_shl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd6 && src_b >= DATA_W) |-> (dst == '0));

endmodule

bind alu16_zf alu16_zf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_b(src_b), .op(op), .dst(dst), .zero_flag(zero_flag)
);

// File: tb/tb_alu16_zf.sv
// Bench: scoreboard for alu16_zf. The driver queues the expected result and flag,
// and the monitor compares them after each rising edge.
module tb_alu16_zf;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] dst;
        logic         flag;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] dst;
    logic         zero_flag;

    int   checks = 0;
    int   errors = 0;
    logic flag_model = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    alu16_zf dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .op(op), .dst(dst), .zero_flag(zero_flag)
    );

    always #2 clk = ~clk;

    // Work out the result from the requirements alone.
    function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        case (o)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a + b;
            3'd3: return a - b;
            3'd4: return a ^ b;
            3'd5: return (b >= W) ? '0 : a >> b;
            3'd6: return (b >= W) ? '0 : a << b;
            default: return b;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one operation, check dst before the edge (R10), and queue the expectation.
    task automatic drive(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req);
        exp_t e;
        @(negedge clk);
        op = o; src_a = a; src_b = b;
        e.dst = model(o, a, b);
        if (o == 3'd2 || o == 3'd3) flag_model = (e.dst == '0);
        e.flag = flag_model;
        e.req = req;
        #1;
        check("R10", "dst before edge", dst, e.dst);
        sb.push_back(e);
    endtask

    // Monitor: after each rising edge, compare against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "dst", dst, e.dst);
                check(e.req, "zero_flag", {15'd0, zero_flag}, {15'd0, e.flag});
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R9", "flag in reset", {15'd0, zero_flag}, 16'd0);
        rst_n = 1'b1;

        drive(3'd2, 16'h0005, 16'h0003, "R2 R7 add");
        drive(3'd3, 16'h1234, 16'h1234, "R3 R7 sub zero");
        drive(3'd0, 16'hF0F0, 16'h3C3C, "R1 R8 and");
        drive(3'd1, 16'hF0F0, 16'h3C3C, "R1 R8 or");
        drive(3'd4, 16'hF0F0, 16'h3C3C, "R1 R8 xor");
        drive(3'd5, 16'h8001, 16'd15, "R4 shr 15");
        drive(3'd5, 16'hFFFF, 16'd16, "R4 shr 16");
        drive(3'd5, 16'hA5A5, 16'd3, "R4 shr 3");
        drive(3'd6, 16'h8001, 16'd15, "R5 shl 15");
        drive(3'd6, 16'hFFFF, 16'd20, "R5 shl 20");
        drive(3'd6, 16'hA5A5, 16'd4, "R5 shl 4");
        drive(3'd7, 16'h1111, 16'hBEEF, "R6 load");
        drive(3'd3, 16'h0000, 16'h0001, "R3 R7 sub wrap");
        drive(3'd7, 16'h1111, 16'h0000, "R8 load zero holds clear");
        drive(3'd0, 16'h00FF, 16'hFF00, "R8 and zero holds clear");
        drive(3'd2, 16'hFFFF, 16'h0001, "R2 R7 add wrap");
        drive(3'd4, 16'h5555, 16'hAAAA, "R8 xor nonzero holds set");
        drive(3'd6, 16'h0001, 16'd1, "R8 shl nonzero holds set");

        // Asynchronous clear in the middle of a cycle with the flag set.
        @(posedge clk);
        #1;
        op = 3'd0;
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check("R9", "async clear before edge", {15'd0, zero_flag}, 16'd0);
        flag_model = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        drive(3'd2, 16'h0010, 16'h0020, "R7 add after reset");
        drive(3'd3, 16'h0040, 16'h0040, "R7 sub zero after reset");
        drive(3'd1, 16'h0000, 16'h0000, "R8 or zero holds set");

        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule